// File: doc/BRIEF.md
# Synchronizable Sample Timebase With Handshake

This block paces a sampled-signal pipeline and carries each sample from the converter front end, through a processing stage, to the output stage. After reset it spends a fixed observation window watching an asynchronous sync-clock input. It then latches a mode flag. If at least one rising edge was seen, every conversion start is slaved to a rising edge of that input. Otherwise an internal divider issues conversion starts at a fixed period.

At each conversion start, the block captures the converter readout, which is the result of the previous conversion. It holds that value in a staging register until a single-entry input mailbox is empty. The processing stage reads the mailbox and clears its full flag. A second single-entry mailbox takes the processed value. At the next conversion start, the output stage empties that mailbox and issues the value with a one-cycle load pulse.

A sample therefore spends one period being converted, one period being processed and one period in output transfer. If a new conversion start arrives while the staged sample is still waiting for the input mailbox, a sticky overrun flag is raised.

Top module: `sync_sample_timebase`

## Requirements
- R1: In reset, and just after it, `convStart`, `modeValid`, `syncMode`, `inFull`, `outFull`, `dacLoad` and `overrun` are all 0.
- R2: After reset is released, `modeValid` rises at the DETECT_TICKS-th rising clock edge, and no `convStart` pulse occurs before `modeValid` is 1.
- R3: `syncMode` is latched when `modeValid` rises. It is 1 if a rising edge of `extSync` was detected after the SYNC_STAGES-flop synchronizer during the window, and 0 otherwise. It then holds until reset.
- R4: With `syncMode` = 0, `convStart` is a one-cycle pulse repeating every DIV clock cycles, and `extSync` has no effect on it.
- R5: With `syncMode` = 1, each rising edge of `extSync` gives exactly one `convStart` pulse. That pulse is high in the cycle after the second rising clock edge that samples the new level. No pulse occurs without an edge.
- R6: The clock edge that ends a `convStart` cycle captures `sampleIn` into staging. If the input mailbox is empty, the staged value moves into it on the next edge, setting `inFull` = 1 with `inData` equal to that value. An edge with `inTake` = 1 clears `inFull`.
- R7: While `inFull` = 1, a staged sample waits and `inData` is left unchanged. The staged sample moves in on the edge after `inFull` is cleared.
- R8: `overrun` becomes 1 when a `convStart` cycle ends while a staged sample is still waiting. After that it stays 1 until reset.
- R9: A `procWrite` is accepted only while `outFull` = 0, and acceptance sets `outFull`. A `procWrite` while `outFull` = 1 has no effect on the held value.
- R10: At the end of a `convStart` cycle with `outFull` = 1, the held value goes to `dacData` and `outFull` clears. `dacLoad` is 1 for exactly the following cycle. A sample captured at one conversion start is therefore issued right after the next conversion start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extSync | input | 1 | Asynchronous external sync-clock input |
| sampleIn | input | W | Converter readout (previous conversion result) |
| inTake | input | 1 | Processing stage has read the input mailbox |
| procData | input | W | Processed sample to write |
| procWrite | input | 1 | Write request into the output mailbox |
| convStart | output | 1 | One-cycle conversion-start strobe |
| modeValid | output | 1 | Observation window finished, mode latched |
| syncMode | output | 1 | 1: slaved to extSync, 0: internal divider |
| inData | output | W | Input mailbox contents |
| inFull | output | 1 | Input mailbox holds an unread sample |
| outFull | output | 1 | Output mailbox holds an unissued sample |
| dacData | output | W | Sample issued to the output converter |
| dacLoad | output | 1 | One-cycle load pulse for dacData |
| overrun | output | 1 | Sticky: a sample arrived while one was still waiting |

## Verification
The bench builds the block with DIV = 16 and DETECT_TICKS = 64. Both the observation window and dozens of internal sample periods then fit in a few hundred cycles, and the exact window length and strobe spacing are checked cycle by cycle. External-mode runs use pulses 20 cycles apart. This spacing leaves room for a modelled one-cycle processing stage, so the three-period pipeline runs end to end. Stopping that stage then lets the bench fill the mailbox, the staging register and the overrun condition in a controlled order.

// File: rtl/ts_pkg.sv
package ts_pkg;
  // Strobes from control to datapath, one per register load.
  typedef struct packed {
    logic capture;    // latch converter readout into staging
    logic moveIn;     // staging -> input mailbox
    logic acceptOut;  // processed value -> output mailbox
    logic issueOut;   // output mailbox -> output register
  } tsStrobe_t;
endpackage

// File: rtl/ts_sync_edge.sv
module ts_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic rise
);
  // STAGES synchronizing flops plus one history flop for the edge detect.
  logic [STAGES:0] shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shReg <= '0;
    else       shReg <= {shReg[STAGES-1:0], asyncIn};
  end

  assign rise = shReg[STAGES-1] & ~shReg[STAGES];
endmodule

// File: rtl/ts_control.sv
module ts_control
  import ts_pkg::*;
#(
  parameter int DIV          = 800,
  parameter int DETECT_TICKS = 4096
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      syncRise,
  input  logic      inTake,
  input  logic      procWrite,
  output logic      convStart,
  output logic      modeValid,
  output logic      syncMode,
  output logic      inFull,
  output logic      outFull,
  output logic      overrun,
  output logic      dacLoad,
  output tsStrobe_t strobes
);
  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int DET_W = (DETECT_TICKS > 1) ? $clog2(DETECT_TICKS) : 1;

  logic [DIV_W-1:0] divCnt;
  logic [DET_W-1:0] detCnt;
  logic sawPulse;
  logic stagedPending;
  logic divWrap, tick, move, accept, issue;

  always_comb begin
    divWrap = (divCnt == DIV_W'(DIV - 1));
    tick    = modeValid & (syncMode ? syncRise : divWrap);
    move    = stagedPending & ~inFull;
    accept  = procWrite & ~outFull;
    issue   = tick & outFull;
    strobes = '{capture: tick, moveIn: move, acceptOut: accept, issueOut: issue};
  end

  assign convStart = tick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      detCnt        <= '0;
      sawPulse      <= 1'b0;
      modeValid     <= 1'b0;
      syncMode      <= 1'b0;
      divCnt        <= '0;
      stagedPending <= 1'b0;
      overrun       <= 1'b0;
      inFull        <= 1'b0;
      outFull       <= 1'b0;
      dacLoad       <= 1'b0;
    end else begin
      // Startup observation window
      if (!modeValid) begin
        detCnt   <= detCnt + 1'b1;
        sawPulse <= sawPulse | syncRise;
        if (detCnt == DET_W'(DETECT_TICKS - 1)) begin
          modeValid <= 1'b1;
          syncMode  <= sawPulse | syncRise;
        end
      end
      // Internal rate divider
      if (modeValid && !syncMode) divCnt <= divWrap ? '0 : divCnt + 1'b1;
      // Producer side of the input mailbox
      stagedPending <= tick | (stagedPending & ~move);
      overrun       <= overrun | (tick & stagedPending & ~move);
      inFull        <= move | (inFull & ~inTake);
      // Output mailbox and output stage
      outFull       <= accept | (outFull & ~issue);
      dacLoad       <= issue;
    end
  end
endmodule

// File: rtl/ts_datapath.sv
module ts_datapath
  import ts_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  tsStrobe_t    strobes,
  input  logic [W-1:0] sampleIn,
  input  logic [W-1:0] procData,
  output logic [W-1:0] inData,
  output logic [W-1:0] dacData
);
  logic [W-1:0] stageReg;
  logic [W-1:0] outBox;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageReg <= '0;
      inData   <= '0;
      outBox   <= '0;
      dacData  <= '0;
    end else begin
      if (strobes.capture)   stageReg <= sampleIn;
      if (strobes.moveIn)    inData   <= stageReg;
      if (strobes.acceptOut) outBox   <= procData;
      if (strobes.issueOut)  dacData  <= outBox;
    end
  end
endmodule

// File: rtl/sync_sample_timebase.sv
module sync_sample_timebase
  import ts_pkg::*;
#(
  parameter int W            = 16,
  parameter int DIV          = 800,
  parameter int DETECT_TICKS = 4096,
  parameter int SYNC_STAGES  = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         extSync,
  input  logic [W-1:0] sampleIn,
  input  logic         inTake,
  input  logic [W-1:0] procData,
  input  logic         procWrite,
  output logic         convStart,
  output logic         modeValid,
  output logic         syncMode,
  output logic [W-1:0] inData,
  output logic         inFull,
  output logic         outFull,
  output logic [W-1:0] dacData,
  output logic         dacLoad,
  output logic         overrun
);
  logic      syncRise;
  tsStrobe_t strobes;

  ts_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(extSync), .rise(syncRise)
  );

  ts_control #(.DIV(DIV), .DETECT_TICKS(DETECT_TICKS)) u_ctl (
    .clk(clk), .rstN(rstN), .syncRise(syncRise), .inTake(inTake),
    .procWrite(procWrite), .convStart(convStart), .modeValid(modeValid),
    .syncMode(syncMode), .inFull(inFull), .outFull(outFull),
    .overrun(overrun), .dacLoad(dacLoad), .strobes(strobes)
  );

  ts_datapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sampleIn(sampleIn),
    .procData(procData), .inData(inData), .dacData(dacData)
  );
endmodule

// File: rtl/ts_checker.sv
module ts_checker (
  input logic clk,
  input logic rstN,
  input logic convStart,
  input logic modeValid,
  input logic syncMode,
  input logic inFull,
  input logic inTake,
  input logic outFull,
  input logic overrun,
  input logic dacLoad
);
  assert_no_strobe_in_window_R2: assert property (@(posedge clk) disable iff (!rstN)
    !modeValid |-> !convStart);

  assert_mode_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    modeValid |=> (modeValid && $stable(syncMode)));

  // R4 and R5: strobes are single-cycle pulses in either mode
  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  assert_inbox_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inFull && !inTake) |=> inFull);

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

  assert_outbox_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outFull && !convStart) |=> outFull);

  assert_load_after_strobe_R10: assert property (@(posedge clk) disable iff (!rstN)
    dacLoad |-> ($past(convStart) && !outFull));
endmodule

bind sync_sample_timebase ts_checker u_chk (
  .clk(clk), .rstN(rstN), .convStart(convStart), .modeValid(modeValid),
  .syncMode(syncMode), .inFull(inFull), .inTake(inTake), .outFull(outFull),
  .overrun(overrun), .dacLoad(dacLoad)
);

// File: tb/sim_sync_sample_timebase.sv
`timescale 1ns/1ps
module sim_sync_sample_timebase;
  localparam int W  = 16;
  localparam int DV = 16;
  localparam int DT = 64;

  logic clk = 1'b0;
  logic rstN, extSync, inTake, procWrite;
  logic [W-1:0] sampleIn, procData, inData, dacData;
  logic convStart, modeValid, syncMode, inFull, outFull, dacLoad, overrun;

  always #4 clk = ~clk;

  sync_sample_timebase #(.W(W), .DIV(DV), .DETECT_TICKS(DT), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rstN(rstN), .extSync(extSync), .sampleIn(sampleIn),
    .inTake(inTake), .procData(procData), .procWrite(procWrite),
    .convStart(convStart), .modeValid(modeValid), .syncMode(syncMode),
    .inData(inData), .inFull(inFull), .outFull(outFull), .dacData(dacData),
    .dacLoad(dacLoad), .overrun(overrun)
  );

  int checks = 0, fails = 0;
  int cyc = 0, lastStrobeCyc = 0, strobeCnt = 0, sbCount = 0;
  bit haveLast = 0, chkSpacing = 0, svcOn = 0, updPending = 0;
  logic [W-1:0] lastCap;
  logic [W-1:0] expQ[$];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor / scoreboard: push at each strobe, pop at each output load
  always @(negedge clk) begin
    cyc++;
    if (updPending) begin
      sampleIn   = sampleIn + 16'h0137;
      updPending = 0;
    end
    if (convStart) begin
      lastCap = sampleIn;
      if (svcOn) expQ.push_back(sampleIn ^ 16'h5A5A);
      if (chkSpacing && haveLast) check(cyc - lastStrobeCyc == DV, "R4", cyc - lastStrobeCyc, DV);
      lastStrobeCyc = cyc;
      haveLast      = 1;
      strobeCnt++;
      updPending    = 1;
    end
    if (dacLoad && svcOn) begin
      check(cyc - lastStrobeCyc == 1, "R10", cyc - lastStrobeCyc, 1);
      if (expQ.size() == 0) check(0, "R10", dacData, 0);
      else begin
        logic [W-1:0] e;
        e = expQ.pop_front();
        check(dacData == e, "R9/R10", dacData, e);
        sbCount++;
      end
    end
  end

  // Processing-stage model: one-cycle read and write, then an extra write while full
  initial begin
    forever begin
      @(negedge clk);
      if (svcOn && inFull) begin
        inTake = 1; procWrite = 1; procData = inData ^ 16'h5A5A;
        @(negedge clk);
        inTake = 0; procData = 16'hDEAD;  // R9: must be ignored, mailbox full
        @(negedge clk);
        procWrite = 0;
      end
    end
  end

  task automatic syncPulse(input int gap);
    @(negedge clk) extSync = 1;
    repeat (3) @(negedge clk);
    extSync = 0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    logic [W-1:0] cap1, cap3;
    int k, n0, s0;
    rstN = 0; extSync = 0; inTake = 0; procWrite = 0; procData = '0;
    sampleIn = 16'h0100;
    repeat (5) @(negedge clk);
    check({convStart, modeValid, syncMode, inFull, outFull, dacLoad, overrun} == 7'b0,
          "R1", {convStart, modeValid, syncMode, inFull, outFull, dacLoad, overrun}, 0);

    // Phase A: internal timebase
    svcOn = 1;
    rstN = 1;
    k = 0;
    do begin @(negedge clk); k++; end while (!modeValid && k < 1000);
    check(k == DT, "R2", k, DT);
    check(strobeCnt == 0, "R2", strobeCnt, 0);
    check(syncMode == 0, "R3", syncMode, 0);
    chkSpacing = 1;
    repeat (12 * DV) @(negedge clk);
    s0 = strobeCnt;
    for (int i = 0; i < 6; i++) syncPulse(9);  // R4: ignored in internal mode
    repeat (2 * DV) @(negedge clk);
    check(syncMode == 0, "R3", syncMode, 0);
    check(strobeCnt - s0 >= 5, "R4", strobeCnt - s0, 5);
    check(sbCount >= 10, "R10", sbCount, 10);
    svcOn = 0;
    repeat (10) @(negedge clk);
    chkSpacing = 0;
    expQ.delete();

    // Phase B: external sync
    rstN = 0;
    repeat (3) @(negedge clk);
    check({convStart, modeValid, syncMode, inFull, outFull, dacLoad, overrun} == 7'b0,
          "R1", {convStart, modeValid, syncMode, inFull, outFull, dacLoad, overrun}, 0);
    strobeCnt = 0; haveLast = 0; sbCount = 0;
    svcOn = 1;
    rstN = 1;
    repeat (10) @(negedge clk);
    syncPulse(4);
    while (!modeValid) @(negedge clk);
    check(syncMode == 1, "R3", syncMode, 1);
    check(strobeCnt == 0, "R2", strobeCnt, 0);
    repeat (4) @(negedge clk);
    @(negedge clk) extSync = 1;
    @(negedge clk) check(convStart == 0, "R5", convStart, 0);
    @(negedge clk) check(convStart == 1, "R5", convStart, 1);
    @(negedge clk) check(convStart == 0, "R5", convStart, 0);
    extSync = 0;
    n0 = strobeCnt;
    repeat (100) @(negedge clk);
    check(strobeCnt == n0, "R5", strobeCnt, n0);
    for (int i = 0; i < 12; i++) syncPulse(16);
    check(strobeCnt - n0 == 12, "R5", strobeCnt - n0, 12);
    check(sbCount >= 11, "R10", sbCount, 11);

    // Phase C: stalled consumer, mailbox hold and overrun
    svcOn = 0;
    repeat (10) @(negedge clk);
    expQ.delete();
    check(inFull == 0, "R6", inFull, 0);
    syncPulse(16);
    cap1 = lastCap;
    check(inFull == 1 && inData == cap1, "R6", inData, cap1);
    syncPulse(16);
    check(inData == cap1, "R7", inData, cap1);
    check(overrun == 0, "R8", overrun, 0);
    syncPulse(16);
    cap3 = lastCap;
    check(overrun == 1, "R8", overrun, 1);
    @(negedge clk) inTake = 1;
    @(negedge clk) inTake = 0;
    check(inFull == 0, "R6", inFull, 0);
    @(negedge clk);
    check(inFull == 1 && inData == cap3, "R7", inData, cap3);
    @(negedge clk) inTake = 1;
    @(negedge clk) inTake = 0;
    syncPulse(16);
    check(overrun == 1, "R8", overrun, 1);
    rstN = 0;
    @(negedge clk);
    check(overrun == 0, "R1", overrun, 0);
    summary();
  end
endmodule